// File: doc/BRIEF.md
# Translation Fault Checker

This block judges one virtual-to-physical translation per request. A request carries the first word of the segment descriptor, the base address of the segment, the page descriptor, the virtual address, the requested access type and the current processor mode. The block looks at the segment kind, contiguous or paged. It applies the permission check for the current mode, then the segment-offset bound check, then the page-present check. It reports the first fault found. When no fault is found it produces the physical address.

Fault capture is a per-request control. When capture is on, a fault loads two registers. The first is a fault-code register that packs access type, mode and fault reason. The second is a fault-address register that holds the offending virtual address. When capture is off, the permission check is skipped. Bound and presence faults are still reported, and both fault registers keep their old contents.

The block samples its inputs on the edge where `req_valid` is high. All results appear at registered outputs one cycle later.

Top module: `tfc_fault_checker`

## Requirements
- R1: After synchronous reset, every output is zero.
- R2: `rsp_valid` is high for exactly the one cycle after each cycle in which `req_valid` was sampled high.
- R3: Descriptor bit 2 selects the segment kind: 1 means contiguous, 0 means paged. The 2-bit permission field for mode m sits at bits [24+2m+1:24+2m] of the segment descriptor for contiguous segments. For paged segments it sits at bits [2+2m+1:2+2m] of the page descriptor. The field codes are 0 none, 1 execute, 2 read-execute, 3 read-write. An access type of 0 is a fetch and needs level 1 or more. An access type of 2 is a write and needs level 3. Any other access type is a read and needs level 2 or more. With capture on, a shortfall gives fault number 1.
- R4: For a contiguous segment, fault number 2 is raised when va[16:0] is greater than or equal to the limit. The limit is (sd0[23:10] + 1) × 8.
- R5: For a paged segment, when page descriptor bit 1 (last page) is set, fault number 2 is raised when va[16:0] is greater than or equal to the same limit. When bit 1 is clear, no bound check is made.
- R6: For a paged segment, fault number 3 is raised when page descriptor bit 0 (present) is clear.
- R7: When several faults apply, the permission fault wins over the offset fault, and the offset fault wins over the not-present fault. `fault` is high exactly when the fault number is not 0.
- R8: With capture off, no permission fault is raised, offset and not-present faults are still reported, and `fault_code` and `fault_addr` keep their old values.
- R9: With capture on and a fault found, `fault_code` becomes {access type, mode, 3'b000, fault number}. This puts the access type at bit 7, the mode at bit 5 and the fault number at bit 0. `fault_addr` becomes the virtual address. A request without a fault leaves both registers unchanged.
- R10: For a paged segment without a fault, `phys_addr` is {pd[31:11], va[10:0]}.
- R11: For a contiguous segment without a fault, `phys_addr` is the segment base plus va[16:0]. On any fault, `phys_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs are sampled on this edge |
| req_sd0 | input | 32 | Segment descriptor word 0 (kind, limit field, permissions) |
| req_seg_base | input | 32 | Segment base address for contiguous segments |
| req_pd | input | 32 | Page descriptor (frame, permissions, last, present) |
| req_va | input | 32 | Virtual address |
| req_acc | input | 4 | Requested access type |
| req_mode | input | 2 | Current processor mode |
| req_capture | input | 1 | Fault capture enable for this request |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| fault | output | 1 | A fault was found |
| fault_num | output | 2 | 0 none, 1 permission, 2 segment offset, 3 page absent |
| phys_addr | output | 32 | Physical address, 0 on fault |
| fault_code | output | 11 | Captured fault code register |
| fault_addr | output | 32 | Captured faulting virtual address register |

## Verification
A single request can trip the permission check and the segment-offset bound at the same time. It can also trip the offset bound and the absent-page check together. The bench provokes both collisions with directed requests. In one, a contiguous segment has no rights for the mode and an offset past the limit. In another, a paged last-page segment has an offset past the limit and a cleared present bit. Each collision is run with capture on and with capture off. The behavioural model in the bench judges the priority and the register capture on every clock.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  // descriptor field positions
  localparam int SD_KIND_BIT    = 2;
  localparam int SD_LIMIT_LO    = 10;
  localparam int SD_PERM_LO     = 24;
  localparam int PD_PRESENT_BIT = 0;
  localparam int PD_LAST_BIT    = 1;
  localparam int PD_PERM_LO     = 2;

  // access type codes
  localparam int ACC_FETCH = 0;
  localparam int ACC_WRITE = 2;

  localparam int FNUM_W = 5;  // width of fault field in the code register

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ACCESS = 2'd1,
    FLT_OFFSET = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_EXEC = 2'd1,
    LVL_RDEX = 2'd2,
    LVL_RDWR = 2'd3
  } perm_e;
endpackage

// File: rtl/tfc_perm_check.sv
module tfc_perm_check
  import tfc_pkg::*;
#(
  parameter  int MODE_W = 2,
  parameter  int ACC_W  = 4,
  localparam int NMODE  = 1 << MODE_W
) (
  input  logic [2*NMODE-1:0] perm_field,
  input  logic [MODE_W-1:0]  mode,
  input  logic [ACC_W-1:0]   acc,
  output logic               allowed
);
  logic [1:0] lvl [NMODE];
  perm_e      need;

  for (genvar g = 0; g < NMODE; g++) begin : g_split
    assign lvl[g] = perm_field[2*g +: 2];
  end

  always_comb begin
    if (acc == ACC_W'(ACC_FETCH))      need = LVL_EXEC;
    else if (acc == ACC_W'(ACC_WRITE)) need = LVL_RDWR;
    else                               need = LVL_RDEX;
  end

  assign allowed = (lvl[mode] >= need);
endmodule

// File: rtl/tfc_bound_check.sv
module tfc_bound_check #(
  parameter  int OFF_W  = 17,
  parameter  int MAXF_W = 14,
  localparam int LIM_W  = MAXF_W + 4
) (
  input  logic [OFF_W-1:0]  seg_off,
  input  logic [MAXF_W-1:0] limit_field,
  input  logic              check_en,
  output logic              over
);
  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] off_ext;

  // limit in bytes: (field + 1) * 8
  assign limit   = (LIM_W'(limit_field) + LIM_W'(1)) << 3;
  assign off_ext = LIM_W'(seg_off);
  assign over    = check_en && (off_ext >= limit);
endmodule

// File: rtl/tfc_addr_gen.sv
module tfc_addr_gen #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 17,
  parameter int PG_W  = 11
) (
  input  logic            contig,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] frame_word,
  input  logic [VA_W-1:0] seg_base,
  output logic [VA_W-1:0] phys
);
  logic [VA_W-1:0] paged_pa;
  logic [VA_W-1:0] contig_pa;

  assign paged_pa  = {frame_word[VA_W-1:PG_W], va[PG_W-1:0]};
  assign contig_pa = seg_base + VA_W'(va[OFF_W-1:0]);
  assign phys      = contig ? contig_pa : paged_pa;
endmodule

// File: rtl/tfc_fault_checker.sv
module tfc_fault_checker
  import tfc_pkg::*;
#(
  parameter  int VA_W   = 32,
  parameter  int ACC_W  = 4,
  parameter  int MODE_W = 2,
  parameter  int OFF_W  = 17,
  parameter  int PG_W   = 11,
  parameter  int MAXF_W = 14,
  localparam int CODE_W = ACC_W + MODE_W + FNUM_W,
  localparam int PF_W   = 2 * (1 << MODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_sd0,
  input  logic [VA_W-1:0]   req_seg_base,
  input  logic [VA_W-1:0]   req_pd,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ACC_W-1:0]  req_acc,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_capture,
  output logic              rsp_valid,
  output logic              fault,
  output logic [1:0]        fault_num,
  output logic [VA_W-1:0]   phys_addr,
  output logic [CODE_W-1:0] fault_code,
  output logic [VA_W-1:0]   fault_addr
);
  logic            contig;
  logic [PF_W-1:0] perm_sel;
  logic            allowed;
  logic            over;
  logic            present;
  logic [VA_W-1:0] pa_calc;
  fault_e          verdict;

  assign contig   = req_sd0[SD_KIND_BIT];
  assign perm_sel = contig ? req_sd0[SD_PERM_LO +: PF_W] : req_pd[PD_PERM_LO +: PF_W];
  assign present  = req_pd[PD_PRESENT_BIT];

  tfc_perm_check #(.MODE_W(MODE_W), .ACC_W(ACC_W)) u_perm (
    .perm_field (perm_sel),
    .mode       (req_mode),
    .acc        (req_acc),
    .allowed    (allowed)
  );

  tfc_bound_check #(.OFF_W(OFF_W), .MAXF_W(MAXF_W)) u_bound (
    .seg_off     (req_va[OFF_W-1:0]),
    .limit_field (req_sd0[SD_LIMIT_LO +: MAXF_W]),
    .check_en    (contig | req_pd[PD_LAST_BIT]),
    .over        (over)
  );

  tfc_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .PG_W(PG_W)) u_addr (
    .contig     (contig),
    .va         (req_va),
    .frame_word (req_pd),
    .seg_base   (req_seg_base),
    .phys       (pa_calc)
  );

  // priority: permission, then offset, then presence (paged only)
  always_comb begin
    if (req_capture && !allowed)  verdict = FLT_ACCESS;
    else if (over)                verdict = FLT_OFFSET;
    else if (!contig && !present) verdict = FLT_ABSENT;
    else                          verdict = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      fault      <= 1'b0;
      fault_num  <= 2'd0;
      phys_addr  <= '0;
      fault_code <= '0;
      fault_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        fault_num <= verdict;
        fault     <= (verdict != FLT_NONE);
        phys_addr <= (verdict == FLT_NONE) ? pa_calc : '0;
        if (req_capture && verdict != FLT_NONE) begin
          fault_code <= {req_acc, req_mode, FNUM_W'(verdict)};
          fault_addr <= req_va;
        end
      end
    end
  end
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
  parameter int VA_W   = 32,
  parameter int ACC_W  = 4,
  parameter int MODE_W = 2,
  parameter int CODE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_sd0,
  input logic [VA_W-1:0]   req_pd,
  input logic [VA_W-1:0]   req_va,
  input logic [ACC_W-1:0]  req_acc,
  input logic [MODE_W-1:0] req_mode,
  input logic              req_capture,
  input logic              rsp_valid,
  input logic              fault,
  input logic [1:0]        fault_num,
  input logic [VA_W-1:0]   phys_addr,
  input logic [CODE_W-1:0] fault_code,
  input logic [VA_W-1:0]   fault_addr
);
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  a_r7_flag_matches_num: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (fault == (fault_num != 2'd0)));

  a_r8_no_perm_fault_uncaptured: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_capture)) |-> (fault_num != 2'd1));

  a_r8_regs_hold: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fault && $past(req_capture)) |-> ($stable(fault_code) && $stable(fault_addr)));

  a_r9_capture_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && fault && $past(req_capture)) |-> (fault_addr == $past(req_va)));

  a_r9_capture_code: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && fault && $past(req_capture)) |->
      (fault_code == {$past(req_acc), $past(req_mode), 3'b000, fault_num}));

  a_r6_absent_paged: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !fault && !$past(req_sd0[2])) |-> $past(req_pd[0]));

  a_r11_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && fault) |-> (phys_addr == '0));
endmodule

bind tfc_fault_checker tfc_checker #(
  .VA_W(VA_W), .ACC_W(ACC_W), .MODE_W(MODE_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_sd0(req_sd0), .req_pd(req_pd),
  .req_va(req_va), .req_acc(req_acc), .req_mode(req_mode), .req_capture(req_capture),
  .rsp_valid(rsp_valid), .fault(fault), .fault_num(fault_num), .phys_addr(phys_addr),
  .fault_code(fault_code), .fault_addr(fault_addr)
);

// File: tb/sim_tfc_fault_checker.sv
`timescale 1ns/1ps
module sim_tfc_fault_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_sd0 = '0, req_seg_base = '0, req_pd = '0, req_va = '0;
  logic [3:0]  req_acc = '0;
  logic [1:0]  req_mode = '0;
  logic        req_capture = 1'b0;
  logic        rsp_valid, fault;
  logic [1:0]  fault_num;
  logic [31:0] phys_addr, fault_addr;
  logic [10:0] fault_code;

  int checks = 0, failures = 0;
  bit started = 0;

  // reference state
  bit          m_rv, m_fault;
  int          m_fnum;
  logic [31:0] m_pa, m_faddr;
  logic [10:0] m_code;
  string       m_tag = "R2";

  always #4 clk = ~clk;

  tfc_fault_checker u0 (.*);

  function automatic int judge(logic [31:0] sd0, logic [31:0] pd, logic [31:0] va,
                               logic [3:0] acc, logic [1:0] mode, bit cap, output string tag);
    int  lim, off, perm, need;
    bit  contig;
    contig = sd0[2];
    lim    = (int'(sd0[23:10]) + 1) * 8;
    off    = int'(va[16:0]);
    perm   = contig ? int'(sd0[24 + 2*mode +: 2]) : int'(pd[2 + 2*mode +: 2]);
    need   = (acc == 0) ? 1 : ((acc == 2) ? 3 : 2);
    if (cap && perm < need) begin tag = "R3"; return 1; end
    if (contig) begin
      tag = "R4";
      return (off >= lim) ? 2 : 0;
    end
    if (pd[1] && off >= lim) begin tag = "R5"; return 2; end
    if (!pd[0]) begin tag = "R6"; return 3; end
    tag = "R10";
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rv = 0; m_fault = 0; m_fnum = 0; m_pa = '0; m_code = '0; m_faddr = '0;
    end else begin
      m_rv = req_valid;
      if (req_valid) begin
        m_fnum  = judge(req_sd0, req_pd, req_va, req_acc, req_mode, req_capture, m_tag);
        m_fault = (m_fnum != 0);
        if (m_fault) m_pa = '0;
        else if (req_sd0[2]) m_pa = req_seg_base + {15'd0, req_va[16:0]};
        else m_pa = {req_pd[31:11], req_va[10:0]};
        if (req_capture && m_fault) begin
          m_code  = {req_acc, req_mode, 3'b000, 2'(m_fnum)};
          m_faddr = req_va;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(rsp_valid == m_rv, "R2", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      chk(fault_num == 2'(m_fnum), m_tag, "fault_num", 32'(fault_num), 32'(m_fnum));
      chk(fault == m_fault, "R7", "fault", 32'(fault), 32'(m_fault));
      chk(phys_addr == m_pa, "R11", "phys_addr", phys_addr, m_pa);
      chk(fault_code == m_code, "R9", "fault_code", 32'(fault_code), 32'(m_code));
      chk(fault_addr == m_faddr, "R8", "fault_addr", fault_addr, m_faddr);
    end
  end

  // sd0 builder: kind, limit field, permission byte
  function automatic logic [31:0] mk_sd(bit contig, int lim_f, logic [7:0] perms);
    return {perms, 14'(lim_f), 7'd0, contig, 2'd0};
  endfunction
  function automatic logic [31:0] mk_pd(logic [20:0] frame, logic [7:0] perms, bit last, bit pres);
    return {frame, 1'b0, perms, last, pres};
  endfunction

  task automatic issue(logic [31:0] sd0, logic [31:0] base, logic [31:0] pd, logic [31:0] va,
                       logic [3:0] acc, logic [1:0] mode, bit cap);
    req_valid = 1; req_sd0 = sd0; req_seg_base = base; req_pd = pd;
    req_va = va; req_acc = acc; req_mode = mode; req_capture = cap;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk({rsp_valid, fault, fault_num, phys_addr, fault_code, fault_addr} == '0,
        "R1", "reset outputs", 32'(rsp_valid), 32'd0);
    started = 1;

    // R10 paged ok, R11 contiguous ok
    issue(mk_sd(0, 100, 8'hFF), 32'h0, mk_pd(21'h1ABCD, 8'hFF, 0, 1), 32'h0001_07F5, 4'd1, 2'd0, 1);
    issue(mk_sd(1, 100, 8'hFF), 32'h4000_0000, '0, 32'h0000_0123, 4'd2, 2'd3, 1);
    // R4 boundary: limit field 3 -> 32 bytes
    issue(mk_sd(1, 3, 8'hFF), 32'h100, '0, 32'd31, 4'd1, 2'd0, 1);
    issue(mk_sd(1, 3, 8'hFF), 32'h100, '0, 32'd32, 4'd1, 2'd1, 1);
    // R5 last page bound, and no bound when last clear
    issue(mk_sd(0, 3, 8'h00), 0, mk_pd(21'h5, 8'hFF, 1, 1), 32'd32, 4'd0, 2'd2, 1);
    issue(mk_sd(0, 3, 8'h00), 0, mk_pd(21'h5, 8'hFF, 0, 1), 32'd32, 4'd0, 2'd2, 1);
    // R6 absent page
    issue(mk_sd(0, 200, 8'h00), 0, mk_pd(21'h7, 8'hFF, 0, 0), 32'h40, 4'd1, 2'd1, 1);
    // R3 levels: execute-only denies read, allows fetch; read-execute denies write
    issue(mk_sd(1, 200, 8'h01), 0, '0, 32'h8, 4'd1, 2'd0, 1);
    issue(mk_sd(1, 200, 8'h01), 0, '0, 32'h8, 4'd0, 2'd0, 1);
    issue(mk_sd(0, 200, 8'h00), 0, mk_pd(21'h9, 8'h80, 0, 1), 32'h8, 4'd2, 2'd3, 1);
    // R7 collisions: perm + offset, offset + absent
    issue(mk_sd(1, 3, 8'h00), 0, '0, 32'd64, 4'd1, 2'd0, 1);
    issue(mk_sd(0, 3, 8'hFF), 0, mk_pd(21'h3, 8'hFF, 1, 0), 32'd64, 4'd1, 2'd0, 1);
    // R8 capture off: same collisions, registers must hold
    issue(mk_sd(1, 3, 8'h00), 0, '0, 32'd64, 4'd1, 2'd0, 0);
    issue(mk_sd(0, 3, 8'hFF), 0, mk_pd(21'h3, 8'hFF, 1, 0), 32'd72, 4'd3, 2'd2, 0);
    issue(mk_sd(1, 100, 8'h00), 32'h20, '0, 32'h10, 4'd2, 2'd1, 0);
    // back-to-back requests (R2)
    req_valid = 1; req_sd0 = mk_sd(1, 50, 8'hFF); req_va = 32'h30; req_capture = 1;
    repeat (3) begin @(negedge clk); req_va = req_va + 32'h100; end
    req_valid = 0;
    @(negedge clk);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] sp, pp;
      sp = 8'($urandom); pp = 8'($urandom);
      issue(mk_sd(1'($urandom), int'($urandom_range(0, 40)), sp), $urandom,
            mk_pd(21'($urandom), pp, 1'($urandom), ($urandom_range(0, 3) != 0)),
            {15'($urandom), 17'($urandom_range(0, 400))},
            4'($urandom_range(0, 4)), 2'($urandom), 1'($urandom));
    end
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule